// File: doc/BRIEF.md
# Delta Sample Fetch Unit

This block keeps a one-byte audio sample buffer topped up from CPU memory. It walks through a sample whose start and size come from two 8-bit settings. Whenever the buffer is empty and the sample still has bytes left, it issues a single-byte memory read and requests a CPU stall. The returned byte lands in the buffer, which is then marked full until the downstream output unit signals that it has taken the byte.

A fetch can start only when the CPU-cycle parity input reports an even cycle. Addresses stay in the upper half of the address space: stepping past the top address continues at the midpoint rather than at zero. At the end of a sample the unit either restarts it from the beginning or, when interrupts are enabled, raises a sticky interrupt flag. That flag is held until software clears it or disables interrupts. Dropping the channel enable abandons the current sample. Raising the enable again while no bytes remain starts the sample over.

Top module: `dsample_fetch`

## Requirements
- R1: A fetch is issued only on a clock edge where `ch_enable` is high, bytes remain, `buf_full` is low, no earlier fetch is still in flight, and `even_phase` is high.
- R2: Each fetch drives `rd_req` high for exactly one cycle with the byte address on `rd_addr`. `stall` rises in that same cycle and stays high for STALL_CYCLES cycles (3 by default).
- R3: Memory answers with a one-cycle latency: `rd_data` is valid in the cycle after `rd_req`. It is stored into `buf_data` at the end of that cycle, so `buf_full` is high two cycles after `rd_req`. A one-cycle `buf_taken` pulse clears `buf_full`.
- R4: After each fetch the address advances by one. The step from 0xFFFF goes to 0x8000.
- R5: A sample starts at address 0xC000 + 64·`start_reg` and holds 16·`len_reg` + 1 bytes.
- R6: With `loop_en` high, the fetch of the last byte reloads the start address and the length, fetching continues without a gap, and `irq` is not raised.
- R7: With `loop_en` low and `irq_en` high, the fetch of the last byte sets `irq`. No further fetches follow, and `irq` stays high until a cycle with `irq_clear` high.
- R8: While `irq_en` is low, `irq` is cleared on the next edge and cannot be set.
- R9: Low `ch_enable` forces the remaining count to zero, so no further fetches are issued. A rising `ch_enable` while the count is zero restarts the sample at its first byte.
- R10: During and right after reset, `rd_req`, `stall`, `buf_full` and `irq` are low, and no fetch happens until `ch_enable` rises.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ch_enable | input | 1 | Channel enable level; a rising edge with no bytes left restarts the sample |
| loop_en | input | 1 | Restart the sample after its last byte |
| irq_en | input | 1 | Allow the end-of-sample interrupt; low clears it |
| irq_clear | input | 1 | Software clear of the interrupt flag |
| start_reg | input | REG_W | Start address setting |
| len_reg | input | REG_W | Sample length setting |
| even_phase | input | 1 | High during even CPU cycles |
| rd_req | output | 1 | One-cycle memory read request |
| rd_addr | output | ADDR_W | Read address |
| rd_data | input | DATA_W | Read data, valid the cycle after rd_req |
| buf_taken | input | 1 | Output unit has consumed the buffer |
| buf_data | output | DATA_W | Sample buffer contents |
| buf_full | output | 1 | Sample buffer holds an unconsumed byte |
| stall | output | 1 | CPU stall request |
| irq | output | 1 | Interrupt flag |

## Verification
The bench uses the default parameters: 16-bit addresses, 8-bit settings and data, and a three-cycle stall. Setting the start to 0xFF places the first byte 64 bytes below the top of memory. A length setting of 4 then crosses the 0xFFFF-to-0x8000 wrap within a 65-byte sample. Short lengths of 1 and 17 bytes keep the looping cases brief, so several passes through a sample fit easily in one run.

// File: rtl/dfu_pkg.sv
package dfu_pkg;

  // Phase of the single-byte read transaction.
  typedef enum logic [1:0] {
    PH_IDLE    = 2'd0,
    PH_ISSUE   = 2'd1,
    PH_CAPTURE = 2'd2
  } dfu_phase_e;

  // Shift that scales the start setting into an address offset.
  localparam int START_SHIFT = 6;
  // Shift that scales the length setting into a byte count.
  localparam int LEN_SHIFT   = 4;

endpackage

// File: rtl/dfu_seq.sv
module dfu_seq #(
  parameter int ADDR_W = 16,
  parameter int REG_W  = 8,
  parameter int LEN_W  = REG_W + dfu_pkg::LEN_SHIFT
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ch_enable,
  input  logic              loop_en,
  input  logic              irq_en,
  input  logic              irq_clear,
  input  logic              issue,
  input  logic [REG_W-1:0]  start_reg,
  input  logic [REG_W-1:0]  len_reg,
  output logic [ADDR_W-1:0] cur_addr,
  output logic              more,
  output logic              irq
);
  localparam logic [ADDR_W-1:0] START_BASE = ADDR_W'(3) << (ADDR_W - 2);
  localparam logic [ADDR_W-1:0] WRAP_BASE  = ADDR_W'(1) << (ADDR_W - 1);
  localparam logic [ADDR_W-1:0] ADDR_TOP   = '1;

  logic [LEN_W-1:0]  remaining;
  logic              en_q;
  logic [ADDR_W-1:0] start_addr;
  logic [LEN_W-1:0]  sample_len;
  logic [ADDR_W-1:0] addr_inc;
  logic              last;
  logic              restart;

  always_comb begin
    start_addr = START_BASE + (ADDR_W'(start_reg) << dfu_pkg::START_SHIFT);
    sample_len = (LEN_W'(len_reg) << dfu_pkg::LEN_SHIFT) + LEN_W'(1);
    addr_inc   = (cur_addr == ADDR_TOP) ? WRAP_BASE : cur_addr + ADDR_W'(1);
    last       = (remaining == LEN_W'(1));
    restart    = ch_enable && !en_q && (remaining == '0);
    more       = (remaining != '0);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cur_addr  <= START_BASE;
      remaining <= '0;
      en_q      <= 1'b0;
    end else begin
      en_q <= ch_enable;
      if (!ch_enable) begin
        remaining <= '0;
      end else if (restart) begin
        cur_addr  <= start_addr;
        remaining <= sample_len;
      end else if (issue) begin
        if (last && loop_en) begin
          cur_addr  <= start_addr;
          remaining <= sample_len;
        end else begin
          cur_addr  <= addr_inc;
          remaining <= remaining - LEN_W'(1);
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      irq <= 1'b0;
    end else if (!irq_en) begin
      irq <= 1'b0;
    end else if (issue && last && !loop_en) begin
      irq <= 1'b1;
    end else if (irq_clear) begin
      irq <= 1'b0;
    end
  end

endmodule

// File: rtl/dfu_stall.sv
module dfu_stall #(
  parameter int STALL_CYCLES = 3
) (
  input  logic clk,
  input  logic rst,
  input  logic start,
  output logic stall
);
  localparam int CNT_W = $clog2(STALL_CYCLES + 1);

  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt   <= '0;
      stall <= 1'b0;
    end else if (start) begin
      cnt   <= CNT_W'(STALL_CYCLES - 1);
      stall <= 1'b1;
    end else if (cnt != '0) begin
      cnt <= cnt - CNT_W'(1);
    end else begin
      stall <= 1'b0;
    end
  end

endmodule

// File: rtl/dfu_sbuf.sv
module dfu_sbuf #(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              issue,
  input  logic [ADDR_W-1:0] issue_addr,
  input  logic [DATA_W-1:0] rd_data,
  input  logic              buf_taken,
  output logic              rd_req,
  output logic [ADDR_W-1:0] rd_addr,
  output logic [DATA_W-1:0] buf_data,
  output logic              buf_full,
  output logic              busy
);
  import dfu_pkg::*;

  dfu_phase_e phase;

  always_ff @(posedge clk) begin
    if (rst) begin
      phase    <= PH_IDLE;
      rd_req   <= 1'b0;
      rd_addr  <= '0;
      buf_data <= '0;
    end else begin
      rd_req <= 1'b0;
      case (phase)
        PH_IDLE: begin
          if (issue) begin
            phase   <= PH_ISSUE;
            rd_req  <= 1'b1;
            rd_addr <= issue_addr;
          end
        end
        PH_ISSUE:   phase <= PH_CAPTURE;
        PH_CAPTURE: begin
          phase    <= PH_IDLE;
          buf_data <= rd_data;
        end
        default:    phase <= PH_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      buf_full <= 1'b0;
    end else if (phase == PH_CAPTURE) begin
      buf_full <= 1'b1;
    end else if (buf_taken) begin
      buf_full <= 1'b0;
    end
  end

  assign busy = (phase != PH_IDLE);

endmodule

// File: rtl/dsample_fetch.sv
module dsample_fetch #(
  parameter int ADDR_W       = 16,
  parameter int DATA_W       = 8,
  parameter int REG_W        = 8,
  parameter int STALL_CYCLES = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ch_enable,
  input  logic              loop_en,
  input  logic              irq_en,
  input  logic              irq_clear,
  input  logic [REG_W-1:0]  start_reg,
  input  logic [REG_W-1:0]  len_reg,
  input  logic              even_phase,
  output logic              rd_req,
  output logic [ADDR_W-1:0] rd_addr,
  input  logic [DATA_W-1:0] rd_data,
  input  logic              buf_taken,
  output logic [DATA_W-1:0] buf_data,
  output logic              buf_full,
  output logic              stall,
  output logic              irq
);
  localparam int LEN_W = REG_W + dfu_pkg::LEN_SHIFT;

  logic [ADDR_W-1:0] cur_addr;
  logic              more;
  logic              busy;
  logic              issue;

  assign issue = ch_enable && more && !buf_full && !busy && even_phase;

  dfu_seq #(
    .ADDR_W (ADDR_W),
    .REG_W  (REG_W),
    .LEN_W  (LEN_W)
  ) u_seq (
    .clk       (clk),
    .rst       (rst),
    .ch_enable (ch_enable),
    .loop_en   (loop_en),
    .irq_en    (irq_en),
    .irq_clear (irq_clear),
    .issue     (issue),
    .start_reg (start_reg),
    .len_reg   (len_reg),
    .cur_addr  (cur_addr),
    .more      (more),
    .irq       (irq)
  );

  dfu_sbuf #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W)
  ) u_sbuf (
    .clk        (clk),
    .rst        (rst),
    .issue      (issue),
    .issue_addr (cur_addr),
    .rd_data    (rd_data),
    .buf_taken  (buf_taken),
    .rd_req     (rd_req),
    .rd_addr    (rd_addr),
    .buf_data   (buf_data),
    .buf_full   (buf_full),
    .busy       (busy)
  );

  dfu_stall #(
    .STALL_CYCLES (STALL_CYCLES)
  ) u_stall (
    .clk   (clk),
    .rst   (rst),
    .start (issue),
    .stall (stall)
  );

endmodule

// File: rtl/dfu_checker.sv
module dfu_checker (
  input logic clk,
  input logic rst,
  input logic even_phase,
  input logic irq_en,
  input logic irq_clear,
  input logic rd_req,
  input logic addr_msb,
  input logic buf_full,
  input logic stall,
  input logic irq
);

  // R1: a request follows an edge where the buffer was empty and the phase even
  assert_issue_gated_R1: assert property (@(posedge clk) disable iff (rst)
    rd_req |-> ($past(even_phase) && !$past(buf_full)));

  // R2: stall accompanies every request
  assert_stall_with_req_R2: assert property (@(posedge clk) disable iff (rst)
    rd_req |-> stall);

  // R2: requests last one cycle
  assert_single_req_R2: assert property (@(posedge clk) disable iff (rst)
    rd_req |=> !rd_req);

  // R3: buffer full two cycles after a request
  assert_fill_after_req_R3: assert property (@(posedge clk) disable iff (rst)
    $past(rd_req, 2) |-> buf_full);

  // R4: addresses stay in the upper half
  assert_upper_half_R4: assert property (@(posedge clk) disable iff (rst)
    rd_req |-> addr_msb);

  // R7: flag holds until cleared
  assert_irq_hold_R7: assert property (@(posedge clk) disable iff (rst)
    (irq && irq_en && !irq_clear) |=> irq);

  // R8: disabled interrupts drop the flag
  assert_irq_gate_R8: assert property (@(posedge clk) disable iff (rst)
    !irq_en |=> !irq);

  // R10: quiet outputs right after reset
  assert_reset_quiet_R10: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (!rd_req && !stall && !buf_full && !irq));

endmodule

bind dsample_fetch dfu_checker u_dfu_checker (
  .clk        (clk),
  .rst        (rst),
  .even_phase (even_phase),
  .irq_en     (irq_en),
  .irq_clear  (irq_clear),
  .rd_req     (rd_req),
  .addr_msb   (rd_addr[ADDR_W-1]),
  .buf_full   (buf_full),
  .stall      (stall),
  .irq        (irq)
);

// File: tb/dsample_fetch_test.sv
module dsample_fetch_test;
  localparam int CLK_PERIOD   = 10;
  localparam int ADDR_W       = 16;
  localparam int DATA_W       = 8;
  localparam int REG_W        = 8;
  localparam int STALL_CYCLES = 3;
  localparam int NVEC         = 5;
  localparam int WATCHDOG     = 100000;

  // {start_reg, len_reg, loop_en, irq_en}
  localparam logic [17:0] VECS [NVEC] = '{
    {8'h00, 8'h00, 1'b0, 1'b1},
    {8'h10, 8'h01, 1'b0, 1'b0},
    {8'hFF, 8'h04, 1'b0, 1'b1},
    {8'h05, 8'h00, 1'b1, 1'b1},
    {8'h20, 8'h01, 1'b1, 1'b0}
  };

  logic              clk = 1'b0;
  logic              rst;
  logic              ch_enable, loop_en, irq_en, irq_clear;
  logic [REG_W-1:0]  start_reg, len_reg;
  logic              even_phase;
  logic              rd_req;
  logic [ADDR_W-1:0] rd_addr;
  logic [DATA_W-1:0] rd_data;
  logic              buf_taken;
  logic [DATA_W-1:0] buf_data;
  logic              buf_full, stall, irq;

  int checks = 0;
  int fails  = 0;

  logic [7:0]        v_s, v_l;
  logic              v_lp, v_ie;
  logic [ADDR_W-1:0] a, base;
  int                n, total;

  always #(CLK_PERIOD/2) clk = ~clk;

  dsample_fetch #(
    .ADDR_W       (ADDR_W),
    .DATA_W       (DATA_W),
    .REG_W        (REG_W),
    .STALL_CYCLES (STALL_CYCLES)
  ) uut (
    .clk        (clk),
    .rst        (rst),
    .ch_enable  (ch_enable),
    .loop_en    (loop_en),
    .irq_en     (irq_en),
    .irq_clear  (irq_clear),
    .start_reg  (start_reg),
    .len_reg    (len_reg),
    .even_phase (even_phase),
    .rd_req     (rd_req),
    .rd_addr    (rd_addr),
    .rd_data    (rd_data),
    .buf_taken  (buf_taken),
    .buf_data   (buf_data),
    .buf_full   (buf_full),
    .stall      (stall),
    .irq        (irq)
  );

  function automatic logic [7:0] mem_byte(input logic [15:0] ad);
    return ad[7:0] ^ {ad[14:8], ad[15]} ^ 8'h5A;
  endfunction

  // Memory with one-cycle read latency
  always @(posedge clk) begin
    if (rd_req) rd_data <= mem_byte(rd_addr);
  end

  // CPU cycle parity
  always @(posedge clk) begin
    if (rst) even_phase <= 1'b0;
    else     even_phase <= ~even_phase;
  end

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic logic [15:0] step_addr(input logic [15:0] ad);
    return (ad == 16'hFFFF) ? 16'h8000 : ad + 16'd1;
  endfunction

  // Follows one fetch from its request through the buffer fill.
  task automatic fetch_one(input logic [15:0] exp_addr, input int hold, input bit take);
    int waited = 0;
    while (!rd_req && waited < 200) begin
      @(negedge clk);
      waited++;
    end
    check(rd_req, "R1", "fetch issued", rd_req, 1);
    check(even_phase == 1'b0, "R1", "issue on even phase", !even_phase, 1);
    check(rd_addr == exp_addr, "R4", "fetch address", rd_addr, exp_addr);
    check(stall, "R2", "stall with request", stall, 1);
    @(negedge clk);
    check(!rd_req, "R2", "single-cycle request", rd_req, 0);
    check(stall, "R2", "stall second cycle", stall, 1);
    check(!buf_full, "R3", "buffer not yet full", buf_full, 0);
    @(negedge clk);
    check(buf_full, "R3", "buffer full", buf_full, 1);
    check(buf_data == mem_byte(exp_addr), "R3", "buffer data", buf_data, mem_byte(exp_addr));
    check(stall, "R2", "stall third cycle", stall, 1);
    @(negedge clk);
    check(!stall, "R2", "stall released", stall, 0);
    for (int h = 0; h < hold; h++) begin
      @(negedge clk);
      check(!rd_req, "R1", "no fetch while full", rd_req, 0);
    end
    if (take) begin
      buf_taken = 1'b1;
      @(negedge clk);
      buf_taken = 1'b0;
      check(!buf_full, "R3", "buffer emptied", buf_full, 0);
    end
  endtask

  task automatic expect_quiet(input string req, input int cycles);
    for (int q = 0; q < cycles; q++) begin
      @(negedge clk);
      check(!rd_req, req, "no fetch", rd_req, 0);
    end
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
  endtask

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog: actual %0d expected 0", WATCHDOG);
    summary();
    $finish;
  end

  initial begin
    rst = 1'b1; ch_enable = 1'b0; loop_en = 1'b0; irq_en = 1'b0; irq_clear = 1'b0;
    start_reg = '0; len_reg = '0; buf_taken = 1'b0;
    repeat (3) @(negedge clk);
    // R10: reset state
    check(!rd_req, "R10", "rd_req in reset", rd_req, 0);
    check(!stall, "R10", "stall in reset", stall, 0);
    check(!buf_full, "R10", "buf_full in reset", buf_full, 0);
    check(!irq, "R10", "irq in reset", irq, 0);
    rst = 1'b0;
    expect_quiet("R10", 10);

    // Vector table: R5 start/length, R4 wrap, R6 loop, R7 interrupt
    for (int v = 0; v < NVEC; v++) begin
      {v_s, v_l, v_lp, v_ie} = VECS[v];
      start_reg = v_s; len_reg = v_l; loop_en = v_lp; irq_en = v_ie;
      ch_enable = 1'b1;
      base  = 16'hC000 + 16'(v_s) * 16'd64;
      n     = 16 * int'(v_l) + 1;
      total = v_lp ? n + 3 : n;
      a = base;
      for (int k = 0; k < total; k++) begin
        fetch_one(a, (k == 0) ? 2 : 0, 1'b1);
        if (v_lp && (k % n) == n - 1) a = base;
        else                          a = step_addr(a);
      end
      ch_enable = 1'b0;
      check(irq == (v_ie && !v_lp), v_lp ? "R6" : "R7", "irq at sample end",
            irq, (v_ie && !v_lp));
      expect_quiet(v_lp ? "R9" : "R7", 12);
      if (irq) begin
        check(irq, "R7", "irq held", irq, 1);
        irq_clear = 1'b1;
        @(negedge clk);
        irq_clear = 1'b0;
        check(!irq, "R7", "irq cleared", irq, 0);
      end
      @(negedge clk);
    end

    // R8: dropping irq_en clears the flag
    start_reg = 8'h02; len_reg = 8'h00; loop_en = 1'b0; irq_en = 1'b1;
    ch_enable = 1'b1;
    fetch_one(16'hC080, 0, 1'b1);
    ch_enable = 1'b0;
    check(irq, "R8", "irq set before gating", irq, 1);
    irq_en = 1'b0;
    @(negedge clk);
    check(!irq, "R8", "irq cleared by irq_en low", irq, 0);
    irq_en = 1'b1;
    @(negedge clk);
    check(!irq, "R8", "irq stays clear", irq, 0);

    // R9: disable mid-sample, then restart from the first byte
    start_reg = 8'h01; len_reg = 8'h01; loop_en = 1'b0; irq_en = 1'b1;
    ch_enable = 1'b1;
    fetch_one(16'hC040, 0, 1'b1);
    fetch_one(16'hC041, 0, 1'b0);
    ch_enable = 1'b0;
    @(negedge clk);
    buf_taken = 1'b1;
    @(negedge clk);
    buf_taken = 1'b0;
    expect_quiet("R9", 12);
    check(!irq, "R9", "no irq after abandon", irq, 0);
    ch_enable = 1'b1;
    fetch_one(16'hC040, 0, 1'b1);
    ch_enable = 1'b0;
    expect_quiet("R9", 6);

    summary();
    $finish;
  end

endmodule